// File: doc/BRIEF.md
# Board Power and Reset Sequencer

This block is the state machine of a board system controller that runs from standby power. A power-button press, or an auto-on strap, starts the main supply. Once that supply reports power good, the block turns on the secondary rails one at a time in index order. It then runs a reset phase and finally releases the processor power-on reset and the device resets. While the board runs, it watches for a reset pushbutton and a software reconfiguration request. Either one takes the board back through the reset phase without dropping power.

The current step is visible as a 4-bit code. The block reports the cause of the latest reset, with the previous cause kept beside it. If a supply fails to come up in time, or a thermal alert arrives, the block switches the rails off in reverse order and records a fault code. That fault stops the auto-on strap from powering the board up again until someone presses the power button.

Top module: `pwr_rst_seq`

## Requirements
- R1: After the synchronous reset, `seq_state` is 0x0, every enable is 0, `por_n` and `dev_rst_n` are 0, `fault_code` and `rst_reason` are 0, and `cfg_q` equals `CFG_DEFAULT`.
- R2: In state 0x0, either of two conditions moves the block to 0x1 and raises `main_en` on the next edge, provided `ot_alert` is low:
  - a falling edge on `pwr_btn_n`;
  - `auto_on`=1 while `fault_code` is 0.
  A button press also clears `fault_code` to 0.
- R3: No rail is enabled before `main_pg` is seen in state 0x1. Rails are enabled in ascending index order, and rail k+1 is enabled only after `rail_good[k]` is high. All of this happens in state 0x2.
- R4: `por_n` is high only in state 0x6. On entry to 0x6, `por_n` rises first and `dev_rst_n` rises one cycle later.
- R5: On entry to state 0x3, `sw_in` is captured into `cfg_q`. State 0x3 lasts exactly `RST_HOLD` cycles and is then followed by 0x4.
- R6: State 0x4 is held until `rmt_ok` is 1. `rmt_waiting` is 1 exactly while the state is 0x4.
- R7: State 0xF is held while `rst_btn_n` is 0 or `cfg_go` is 1. Otherwise the next state is 0x6.
- R8: In 0x6, a low `rst_btn_n` gives 0xD and then 0x3. The pushbutton wins over `cfg_go` when both are active. The reason code for this path is 2.
- R9: In 0x6, with `rst_btn_n` high, `cfg_go`=1 gives 0xE and then 0x3. The reason code for this path is 3.
- R10: `ot_alert` in any powered state (0x1–0x6, 0xD–0xF) gives shutdown state 0x7, sets `fault_code`=3 and sets the reason code to 4.
- R11: A supply that is not good within `TIMEOUT_CYC` cycles of waiting gives 0x7 and the reason code 5. The fault code is 1 when the main supply timed out and 2 when a rail timed out. State 0x1 lasts exactly `TIMEOUT_CYC` cycles when `main_pg` stays low.
- R12: Shutdown runs in a fixed order and then blocks auto-on:
  - in 0x7, the highest enabled rail is cleared on each cycle, one per cycle;
  - once no rail is on, `main_en` drops and the state returns to 0x0;
  - a non-zero `fault_code` keeps 0x0 from restarting on `auto_on`.
- R13: `rst_reason[3:0]` holds the latest cause and `rst_reason[7:4]` holds the one before it. The cause codes are: 1 power-up, 2 pushbutton, 3 reconfiguration, 4 over-temperature, 5 timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_btn_n | input | 1 | Power button, active low |
| auto_on | input | 1 | Strap requesting power-up without a button press |
| main_pg | input | 1 | Main supply power good |
| rail_good | input | N_RAILS | Per-rail good signals |
| rst_btn_n | input | 1 | Reset pushbutton, active low |
| cfg_go | input | 1 | Reconfiguration request bit |
| rmt_ok | input | 1 | Remote permission to leave the wait state |
| ot_alert | input | 1 | Over-temperature alert |
| sw_in | input | SW_W | Configuration switch inputs |
| main_en | output | 1 | Main supply enable |
| rail_en | output | N_RAILS | Rail enables |
| por_n | output | 1 | Processor power-on reset, active low |
| dev_rst_n | output | N_DEV | Device resets, active low |
| seq_state | output | 4 | Encoded sequencer state |
| rmt_waiting | output | 1 | High while waiting for remote permission |
| fault_code | output | 2 | 0 none, 1 main timeout, 2 rail timeout, 3 over-temperature |
| rst_reason | output | 8 | Previous cause [7:4], latest cause [3:0] |
| cfg_q | output | SW_W | Sampled configuration |

## Verification
The bench checks the following corner cases, and what a faulty design would do in each:
- **Both reset requests at once.** The pushbutton and the reconfiguration bit arrive in the same cycle. A design with the wrong priority would pass through 0xE instead of 0xD.
- **Request still held.** A request is still held when the reset phase ends. A design that ignored it in 0xF would release the processor early.
- **Shutdown order.** The bench records the rail enables at every shutdown cycle. A wrong bit order, or clearing more than one rail per cycle, shows up as a mismatch.
- **Exact durations.** The bench counts the cycles of the timeout and of the reset hold, so an off-by-one counter is caught.
- **Auto-on after a fault.** With the strap high after a fault, a design that ignored the fault latch would power straight back up.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [3:0] {
    S_OFF  = 4'h0,
    S_MAIN = 4'h1,
    S_RAIL = 4'h2,
    S_RST  = 4'h3,
    S_RMT  = 4'h4,
    S_RUN  = 4'h6,
    S_SHED = 4'h7,
    S_PBTN = 4'hD,
    S_RCFG = 4'hE,
    S_POST = 4'hF
  } seq_st_e;

  localparam logic [3:0] RSN_NONE  = 4'd0;
  localparam logic [3:0] RSN_PWRUP = 4'd1;
  localparam logic [3:0] RSN_PBTN  = 4'd2;
  localparam logic [3:0] RSN_RCFG  = 4'd3;
  localparam logic [3:0] RSN_HOT   = 4'd4;
  localparam logic [3:0] RSN_TMO   = 4'd5;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_MAIN = 2'd1;
  localparam logic [1:0] FLT_RAIL = 2'd2;
  localparam logic [1:0] FLT_HOT  = 2'd3;
endpackage

// File: rtl/prs_timer.sv
module prs_timer #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R11
  tmr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/prs_rail_bank.sv
module prs_rail_bank #(
  parameter int N_RAILS = 4,
  localparam int IW = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               on_req,
  input  logic [IW-1:0]      on_idx,
  input  logic               shed,
  output logic [N_RAILS-1:0] rail_en,
  output logic               all_off
);
  logic [N_RAILS-1:0] top_mask;

  always_comb begin
    top_mask = '0;
    for (int i = 0; i < N_RAILS; i++) begin
      if (rail_en[i]) begin
        top_mask    = '0;
        top_mask[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rail_en <= '0;
    else if (shed) rail_en <= rail_en & ~top_mask;
    else if (on_req) rail_en[on_idx] <= 1'b1;
  end

  assign all_off = ~|rail_en;

  // R12
  shed_one_chk: assert property (@(posedge clk) disable iff (rst)
    (shed && !all_off) |=> ($countones(rail_en) == $countones($past(rail_en)) - 1));

  generate
    for (genvar k = 1; k < N_RAILS; k++) begin : g_order
      // R3
      rail_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_en[k]) |-> rail_en[k-1]);
    end
  endgenerate
endmodule

// File: rtl/prs_reason.sv
module prs_reason (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap,
  input  logic [3:0] code,
  output logic [3:0] cur,
  output logic [3:0] prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      prev <= '0;
    end else if (cap) begin
      prev <= cur;
      cur  <= code;
    end
  end

  // R13
  reason_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (prev == $past(cur)) && (cur == $past(code)));
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int N_RAILS = 4,
  parameter int N_DEV = 3,
  parameter int SW_W = 8,
  parameter logic [SW_W-1:0] CFG_DEFAULT = 8'hA5,
  parameter int TIMEOUT_CYC = 32,
  parameter int RST_HOLD = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_btn_n,
  input  logic               auto_on,
  input  logic               main_pg,
  input  logic [N_RAILS-1:0] rail_good,
  input  logic               rst_btn_n,
  input  logic               cfg_go,
  input  logic               rmt_ok,
  input  logic               ot_alert,
  input  logic [SW_W-1:0]    sw_in,
  output logic               main_en,
  output logic [N_RAILS-1:0] rail_en,
  output logic               por_n,
  output logic [N_DEV-1:0]   dev_rst_n,
  output logic [3:0]         seq_state,
  output logic               rmt_waiting,
  output logic [1:0]         fault_code,
  output logic [7:0]         rst_reason,
  output logic [SW_W-1:0]    cfg_q
);
  localparam int IW = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam logic [IW-1:0] LAST_RAIL = IW'(N_RAILS - 1);

  seq_st_e st, nxt;
  logic [IW-1:0] idx, on_idx;
  logic btn_prev, press, start, powered;
  logic on_req, shed, all_off, advance;
  logic rsn_cap, fault_set;
  logic [3:0] rsn_code, rsn_cur, rsn_prev;
  logic [1:0] fault_val;
  logic wait_done, hold_done, tmr_clr;

  assign press   = btn_prev && !pwr_btn_n;
  assign start   = !ot_alert && (press || (auto_on && fault_code == FLT_NONE));
  assign powered = st inside {S_MAIN, S_RAIL, S_RST, S_RMT, S_RUN, S_PBTN, S_RCFG, S_POST};
  assign tmr_clr = (st != nxt) || advance;

  prs_timer #(.LIMIT(TIMEOUT_CYC)) u_wait_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr),
    .run((st == S_MAIN) || (st == S_RAIL)), .done(wait_done));

  prs_timer #(.LIMIT(RST_HOLD)) u_hold_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr),
    .run(st == S_RST), .done(hold_done));

  prs_rail_bank #(.N_RAILS(N_RAILS)) u_rails (
    .clk(clk), .rst(rst), .on_req(on_req), .on_idx(on_idx),
    .shed(shed), .rail_en(rail_en), .all_off(all_off));

  prs_reason u_reason (
    .clk(clk), .rst(rst), .cap(rsn_cap), .code(rsn_code),
    .cur(rsn_cur), .prev(rsn_prev));

  always_comb begin
    nxt       = st;
    on_req    = 1'b0;
    on_idx    = idx;
    shed      = 1'b0;
    advance   = 1'b0;
    rsn_cap   = 1'b0;
    rsn_code  = RSN_NONE;
    fault_set = 1'b0;
    fault_val = FLT_NONE;
    if (powered && ot_alert) begin
      nxt       = S_SHED;
      rsn_cap   = 1'b1;
      rsn_code  = RSN_HOT;
      fault_set = 1'b1;
      fault_val = FLT_HOT;
    end else begin
      unique case (st)
        S_OFF: if (start) nxt = S_MAIN;
        S_MAIN: begin
          if (main_pg) begin
            nxt    = S_RAIL;
            on_req = 1'b1;
            on_idx = '0;
          end else if (wait_done) begin
            nxt       = S_SHED;
            rsn_cap   = 1'b1;
            rsn_code  = RSN_TMO;
            fault_set = 1'b1;
            fault_val = FLT_MAIN;
          end
        end
        S_RAIL: begin
          if (rail_good[idx]) begin
            if (idx == LAST_RAIL) begin
              nxt      = S_RST;
              rsn_cap  = 1'b1;
              rsn_code = RSN_PWRUP;
            end else begin
              advance = 1'b1;
              on_req  = 1'b1;
              on_idx  = idx + 1'b1;
            end
          end else if (wait_done) begin
            nxt       = S_SHED;
            rsn_cap   = 1'b1;
            rsn_code  = RSN_TMO;
            fault_set = 1'b1;
            fault_val = FLT_RAIL;
          end
        end
        S_RST:  if (hold_done) nxt = S_RMT;
        S_RMT:  if (rmt_ok) nxt = S_POST;
        S_POST: if (rst_btn_n && !cfg_go) nxt = S_RUN;
        S_RUN: begin
          if (!rst_btn_n) begin
            nxt      = S_PBTN;
            rsn_cap  = 1'b1;
            rsn_code = RSN_PBTN;
          end else if (cfg_go) begin
            nxt      = S_RCFG;
            rsn_cap  = 1'b1;
            rsn_code = RSN_RCFG;
          end
        end
        S_PBTN, S_RCFG: nxt = S_RST;
        S_SHED: begin
          if (!all_off) shed = 1'b1;
          else nxt = S_OFF;
        end
        default: nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_OFF;
      idx         <= '0;
      btn_prev    <= 1'b1;
      fault_code  <= FLT_NONE;
      cfg_q       <= CFG_DEFAULT;
      por_n       <= 1'b0;
      dev_rst_n   <= '0;
      main_en     <= 1'b0;
      rmt_waiting <= 1'b0;
    end else begin
      st       <= nxt;
      btn_prev <= pwr_btn_n;
      if (st == S_MAIN && nxt == S_RAIL) idx <= '0;
      else if (advance) idx <= idx + 1'b1;
      if (st == S_OFF && nxt == S_MAIN) main_en <= 1'b1;
      else if (st == S_SHED && all_off) main_en <= 1'b0;
      if (fault_set) fault_code <= fault_val;
      else if (st == S_OFF && press) fault_code <= FLT_NONE;
      if (nxt == S_RST && st != S_RST) cfg_q <= sw_in;
      por_n       <= (nxt == S_RUN);
      dev_rst_n   <= {N_DEV{por_n && (nxt == S_RUN)}};
      rmt_waiting <= (nxt == S_RMT);
    end
  end

  assign seq_state  = st;
  assign rst_reason = {rsn_prev, rsn_cur};

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_OFF && press && !ot_alert) |=> (st == S_MAIN) && main_en);
  // R3
  rail_needs_main_chk: assert property (@(posedge clk) disable iff (rst)
    (|rail_en) |-> main_en);
  // R4
  por_only_run_chk: assert property (@(posedge clk) disable iff (rst)
    por_n |-> (st == S_RUN));
  // R4
  dev_after_por_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_rst_n[0]) |-> $past(por_n));
  // R6
  rmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RMT && !rmt_ok && !ot_alert) |=> (st == S_RMT) && rmt_waiting);
  // R7
  post_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_POST && !ot_alert && (!rst_btn_n || cfg_go)) |=> (st == S_POST));
  // R10
  hot_shed_chk: assert property (@(posedge clk) disable iff (rst)
    (powered && ot_alert) |=> (st == S_SHED) && (fault_code == FLT_HOT));
  // R12
  fault_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_OFF && fault_code != FLT_NONE && !press) |=> (st == S_OFF));
endmodule

// File: tb/pwr_rst_seq_bench.sv
module pwr_rst_seq_bench;
  localparam int NR = 4;
  localparam int ND = 3;
  localparam int SWW = 8;
  localparam int TMO = 32;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_btn_n = 1'b1, auto_on = 1'b0, main_pg = 1'b0;
  logic [NR-1:0] rail_good = '0;
  logic rst_btn_n = 1'b1, cfg_go = 1'b0, rmt_ok = 1'b0, ot_alert = 1'b0;
  logic [SWW-1:0] sw_in = 8'h3C;
  logic main_en, por_n, rmt_waiting;
  logic [NR-1:0] rail_en;
  logic [ND-1:0] dev_rst_n;
  logic [3:0] seq_state;
  logic [1:0] fault_code;
  logic [7:0] rst_reason;
  logic [SWW-1:0] cfg_q;

  int checks = 0;
  int bad = 0;
  logic [3:0] exp_q[$];
  logic [3:0] last_st = 4'h0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_rst_seq #(.N_RAILS(NR), .N_DEV(ND), .SW_W(SWW), .CFG_DEFAULT(8'hA5),
                .TIMEOUT_CYC(TMO), .RST_HOLD(HOLD)) u_pwr_rst_seq (
    .clk(clk), .rst(rst), .pwr_btn_n(pwr_btn_n), .auto_on(auto_on),
    .main_pg(main_pg), .rail_good(rail_good), .rst_btn_n(rst_btn_n),
    .cfg_go(cfg_go), .rmt_ok(rmt_ok), .ot_alert(ot_alert), .sw_in(sw_in),
    .main_en(main_en), .rail_en(rail_en), .por_n(por_n), .dev_rst_n(dev_rst_n),
    .seq_state(seq_state), .rmt_waiting(rmt_waiting), .fault_code(fault_code),
    .rst_reason(rst_reason), .cfg_q(cfg_q));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every new state must match the head of the expected queue
  always @(negedge clk) begin
    if (rst) last_st = 4'h0;
    else if (seq_state != last_st) begin
      if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected state", int'(seq_state), 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(seq_state == e, "R8", "state order", int'(seq_state), int'(e));
      end
      last_st = seq_state;
    end
  end

  task automatic wait_st(input logic [3:0] s);
    while (seq_state != s) @(negedge clk);
  endtask

  task automatic bring_rails(input int ngood);
    while (!main_en) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rail_en == '0, "R3", "rail before main_pg", int'(rail_en), 0);
    main_pg = 1'b1;
    for (int k = 0; k < ngood; k++) begin
      while (!rail_en[k]) @(negedge clk);
      chk(rail_en == NR'((1 << (k + 1)) - 1), "R3", "rail order", int'(rail_en), (1 << (k + 1)) - 1);
      repeat (2) @(negedge clk);
      chk(rail_en == NR'((1 << (k + 1)) - 1), "R3", "next rail waits good", int'(rail_en), (1 << (k + 1)) - 1);
      rail_good[k] = 1'b1;
    end
  endtask

  task automatic check_shed(input int on_cnt);
    wait_st(4'h7);
    for (int j = 0; j <= on_cnt; j++) begin
      chk(rail_en == NR'((1 << (on_cnt - j)) - 1), "R12", "shed order", int'(rail_en), (1 << (on_cnt - j)) - 1);
      chk(main_en == 1'b1, "R12", "main held during shed", int'(main_en), 1);
      @(negedge clk);
    end
    chk(seq_state == 4'h0 && !main_en, "R12", "main off then idle", int'({main_en, seq_state}), 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(seq_state == 4'h0, "R1", "state", int'(seq_state), 0);
    chk(!main_en && rail_en == '0, "R1", "enables", int'({main_en, rail_en}), 0);
    chk(!por_n && dev_rst_n == '0, "R1", "resets", int'({por_n, dev_rst_n}), 0);
    chk(rst_reason == 8'h00 && fault_code == 2'd0, "R1", "reason/fault", int'(rst_reason), 0);
    chk(cfg_q == 8'hA5, "R1", "cfg default", int'(cfg_q), 8'hA5);
    repeat (4) @(negedge clk);
    chk(seq_state == 4'h0, "R2", "no start without request", int'(seq_state), 0);

    // Power-up by button
    exp_q.push_back(4'h1); exp_q.push_back(4'h2); exp_q.push_back(4'h3);
    exp_q.push_back(4'h4); exp_q.push_back(4'hF); exp_q.push_back(4'h6);
    pwr_btn_n = 1'b0;
    @(negedge clk);
    pwr_btn_n = 1'b1;
    chk(seq_state == 4'h1 && main_en, "R2", "button start", int'(seq_state), 1);
    bring_rails(NR);
    wait_st(4'h3);
    chk(cfg_q == 8'h3C, "R5", "switch sample", int'(cfg_q), 8'h3C);
    chk(!por_n, "R4", "por in reset phase", int'(por_n), 0);
    cfg_go = 1'b1;
    n = 0;
    while (seq_state == 4'h3) begin n++; @(negedge clk); end
    chk(n == HOLD, "R5", "hold length", n, HOLD);
    repeat (5) @(negedge clk);
    chk(seq_state == 4'h4 && rmt_waiting, "R6", "remote wait", int'({rmt_waiting, seq_state}), 8'h14);
    rmt_ok = 1'b1;
    wait_st(4'hF);
    chk(!rmt_waiting, "R6", "flag clears", int'(rmt_waiting), 0);
    repeat (5) @(negedge clk);
    chk(seq_state == 4'hF && !por_n, "R7", "held by cfg_go", int'(seq_state), 4'hF);
    cfg_go = 1'b0;
    wait_st(4'h6);
    chk(por_n && dev_rst_n == '0, "R4", "por first", int'({por_n, dev_rst_n}), 8);
    @(negedge clk);
    chk(dev_rst_n == '1, "R4", "devices released", int'(dev_rst_n), 7);
    chk(rst_reason == 8'h01, "R13", "power-up reason", int'(rst_reason), 1);

    // Pushbutton and reconfig together: pushbutton wins
    exp_q.push_back(4'hD); exp_q.push_back(4'h3); exp_q.push_back(4'h4);
    exp_q.push_back(4'hF); exp_q.push_back(4'h6);
    sw_in = 8'h5A;
    rst_btn_n = 1'b0;
    cfg_go = 1'b1;
    wait_st(4'h3);
    chk(cfg_q == 8'h5A, "R5", "resample", int'(cfg_q), 8'h5A);
    chk(rst_reason == 8'h12, "R8", "pushbutton reason", int'(rst_reason), 8'h12);
    wait_st(4'hF);
    repeat (3) @(negedge clk);
    chk(seq_state == 4'hF, "R7", "held by button", int'(seq_state), 4'hF);
    rst_btn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(seq_state == 4'hF, "R7", "still held by cfg_go", int'(seq_state), 4'hF);
    cfg_go = 1'b0;
    wait_st(4'h6);

    // Reconfiguration
    exp_q.push_back(4'hE); exp_q.push_back(4'h3); exp_q.push_back(4'h4);
    exp_q.push_back(4'hF); exp_q.push_back(4'h6);
    cfg_go = 1'b1;
    wait_st(4'hF);
    chk(rst_reason == 8'h23, "R9", "reconfig reason", int'(rst_reason), 8'h23);
    cfg_go = 1'b0;
    wait_st(4'h6);

    // Over-temperature
    exp_q.push_back(4'h7); exp_q.push_back(4'h0);
    ot_alert = 1'b1;
    check_shed(NR);
    chk(fault_code == 2'd3, "R10", "hot fault", int'(fault_code), 3);
    chk(rst_reason == 8'h34, "R10", "hot reason", int'(rst_reason), 8'h34);
    ot_alert = 1'b0;
    main_pg = 1'b0;
    rail_good = '0;
    auto_on = 1'b1;
    repeat (10) @(negedge clk);
    chk(seq_state == 4'h0, "R12", "fault blocks auto-on", int'(seq_state), 0);

    // Main supply timeout
    exp_q.push_back(4'h1); exp_q.push_back(4'h7); exp_q.push_back(4'h0);
    pwr_btn_n = 1'b0;
    @(negedge clk);
    pwr_btn_n = 1'b1;
    chk(fault_code == 2'd0, "R2", "press clears fault", int'(fault_code), 0);
    n = 0;
    while (seq_state == 4'h1) begin n++; @(negedge clk); end
    chk(n == TMO, "R11", "main timeout length", n, TMO);
    wait_st(4'h0);
    chk(fault_code == 2'd1, "R11", "main fault", int'(fault_code), 1);
    chk(rst_reason == 8'h45, "R13", "timeout reason", int'(rst_reason), 8'h45);

    // Rail timeout on the third rail
    exp_q.push_back(4'h1); exp_q.push_back(4'h2); exp_q.push_back(4'h7); exp_q.push_back(4'h0);
    pwr_btn_n = 1'b0;
    @(negedge clk);
    pwr_btn_n = 1'b1;
    bring_rails(2);
    check_shed(3);
    chk(fault_code == 2'd2, "R11", "rail fault", int'(fault_code), 2);
    chk(rst_reason == 8'h55, "R13", "second timeout", int'(rst_reason), 8'h55);
    main_pg = 1'b0;
    rail_good = '0;

    // Auto-on start after reset
    @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    exp_q.push_back(4'h1);
    rst = 1'b0;
    @(negedge clk);
    chk(seq_state == 4'h1 && main_en, "R2", "auto-on start", int'(seq_state), 1);
    chk(rst_reason == 8'h00, "R1", "reason cleared", int'(rst_reason), 0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all states seen", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL R1 watchdog actual=%0h expected=%0h", seq_state, 6);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule